// File: doc/BRIEF.md
# Two-Channel Tracking-Error Fault Monitor

This block supervises two independent angle-tracking loops. Each cycle it receives, for each channel, the signed difference between the measured and the tracked angle in LSB units, a signed tracking velocity in LSB per second, a strobe marking each period of that channel's excitation reference, and a loss-of-signal flag raised by analog sensing outside the block. A single active-low fault flag reports whether the position word of the currently selected channel can be trusted.

An angle error must grow beyond an upper threshold and stay there across one whole reference period before it raises the fault. Once raised, the fault holds until the error magnitude falls below a lower threshold. The gap between the two thresholds keeps the flag steady when the error hovers near a single boundary. Excess velocity and signal loss raise the fault at once, without any qualifying period. Both channels keep their own state at all times. The select input only chooses which channel drives the shared flag, so a switch of channel shows the other channel's state after one clock.

Top module: `trk_fault_mon`

## Requirements
- R1: During reset `fault_n` is 0. After reset each channel stays faulted until its error magnitude is first seen below `CLR_LSB`. The flag rises on the second clock edge after that input.
- R2: An error magnitude equal to `SET_LSB` (default 55) never raises the fault. Only a magnitude strictly greater than `SET_LSB` counts as over threshold.
- R3: A raised error fault holds while the magnitude is at or above `CLR_LSB` (default 45), including exactly 45. It clears on the first cycle with a magnitude below `CLR_LSB`, and `fault_n` rises one clock later.
- R4: The error fault is raised at the second reference strobe of an unbroken over-threshold run, and `fault_n` falls one clock after that strobe. A single strobe is not enough. Any cycle with the magnitude at or below `SET_LSB` restarts the qualification.
- R5: The error is two's complement, and its magnitude is used. A negative error behaves like the positive error of the same size. The most negative code saturates to the largest magnitude and counts as over threshold.
- R6: Both channels are monitored continuously and independently. The error, strobe, velocity and signal-loss inputs of the unselected channel leave `fault_n` unchanged.
- R7: `sel_a` = 1 selects channel A and `sel_a` = 0 selects channel B. `fault_n` shows the newly selected channel's state one clock after `sel_a` changes.
- R8: A velocity magnitude above `VEL_MAX` (default 327680 LSB/s) faults that channel, with no qualifying period. `fault_n` falls on the second clock edge and returns high on the second edge after the magnitude is back at or below `VEL_MAX`. A value equal to `VEL_MAX` does not fault.
- R9: A high signal-loss flag faults its channel on the second clock edge. The fault releases on the second edge after the flag drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_a | input | ERR_W | Channel A signed angle error, LSB units |
| err_b | input | ERR_W | Channel B signed angle error, LSB units |
| ref_tick_a | input | 1 | One-cycle strobe per channel A reference period |
| ref_tick_b | input | 1 | One-cycle strobe per channel B reference period |
| vel_a | input | VEL_W | Channel A signed tracking velocity, LSB/s |
| vel_b | input | VEL_W | Channel B signed tracking velocity, LSB/s |
| sig_lost_a | input | 1 | Channel A loss-of-signal flag from external sensing |
| sig_lost_b | input | 1 | Channel B loss-of-signal flag from external sensing |
| sel_a | input | 1 | 1 selects channel A, 0 selects channel B |
| fault_n | output | 1 | Active-low fault for the selected channel |

## Verification
The hardest case to reach is the restart of qualification. The error has to be over threshold at one strobe, dip to exactly `SET_LSB` for one cycle between strobes, and then return above threshold. The stimulus holds the error at each edge case (55, 45, 44, the most negative code) while it pulses the strobe by hand, so the fault can only come from the strobe count. Channel isolation is reached by faulting one channel while the other is selected. The bench then checks the flag before and after switching `sel_a`.

// File: rtl/trk_fault_pkg.sv
// Shared types for the tracking-error fault monitor.
// Assumes: none; type definitions only.
package trk_fault_pkg;

    // Qualification state of a channel's over-threshold run.
    typedef enum logic {
        PQ_IDLE  = 1'b0,   // no strobe seen in the current run
        PQ_ARMED = 1'b1    // one strobe seen; the next one qualifies
    } pq_state_t;

endpackage

// File: rtl/trk_mag.sv
// Magnitude of a two's-complement word.
// Output is one bit narrower than the input. The most negative code
// saturates to all ones. Assumes W >= 2.
module trk_mag #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] din,
    output logic        [W-2:0] mag
);
    localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] neg;

    // Negate, then pick the sign-dependent result with saturation.
    always_comb begin
        neg = -din;
        if (!din[W-1])
            mag = din[W-2:0];
        else if (din == MIN_CODE)
            mag = '1;
        else
            mag = neg[W-2:0];
    end
endmodule

// File: rtl/trk_chan_mon.sv
// Fault state for one channel.
// Holds hysteretic angle-error qualification, the velocity limit and the
// registered signal-loss flag. Assumes ref_tick is a one-cycle strobe and
// SET_LSB > CLR_LSB. The error fault starts set after reset.
module trk_chan_mon
    import trk_fault_pkg::*;
#(
    parameter int          ERR_W   = 16,
    parameter int          VEL_W   = 24,
    parameter int unsigned SET_LSB = 55,
    parameter int unsigned CLR_LSB = 45,
    parameter int unsigned VEL_MAX = 327680
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err,
    input  logic                    ref_tick,
    input  logic signed [VEL_W-1:0] vel,
    input  logic                    sig_lost,
    output logic        [ERR_W-2:0] err_mag,
    output logic                    err_latch,
    output logic                    bad
);
    localparam int EM_W = ERR_W - 1;
    localparam int VM_W = VEL_W - 1;
    localparam logic [EM_W-1:0] SET_V = SET_LSB[EM_W-1:0];
    localparam logic [EM_W-1:0] CLR_V = CLR_LSB[EM_W-1:0];
    localparam logic [VM_W-1:0] VEL_V = VEL_MAX[VM_W-1:0];

    logic [VM_W-1:0] vel_mag;
    logic            over;
    logic            vel_q;
    logic            lost_q;
    pq_state_t       pq;

    trk_mag #(.W(ERR_W)) u_err_mag (.din(err), .mag(err_mag));
    trk_mag #(.W(VEL_W)) u_vel_mag (.din(vel), .mag(vel_mag));

    // The over-threshold test is strict.
    assign over = err_mag > SET_V;

    // Set only at the second strobe of an unbroken run; clear only below CLR_V.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_latch <= 1'b1;
            pq        <= PQ_IDLE;
        end else if (err_latch) begin
            pq <= PQ_IDLE;
            if (err_mag < CLR_V)
                err_latch <= 1'b0;
        end else if (!over) begin
            pq <= PQ_IDLE;
        end else if (ref_tick) begin
            if (pq == PQ_ARMED) begin
                err_latch <= 1'b1;
                pq        <= PQ_IDLE;
            end else begin
                pq <= PQ_ARMED;
            end
        end
    end

    // Register the faults that take effect at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vel_q  <= 1'b0;
            lost_q <= 1'b0;
        end else begin
            vel_q  <= vel_mag > VEL_V;
            lost_q <= sig_lost;
        end
    end

    assign bad = err_latch | vel_q | lost_q;
endmodule

// File: rtl/trk_fault_mon.sv
// Two-channel tracking-error fault monitor with a shared active-low flag.
// Both channels run all the time; sel_a picks which one drives fault_n
// through a single output register. Assumes a synchronous active-low reset.
module trk_fault_mon #(
    parameter int          ERR_W   = 16,
    parameter int          VEL_W   = 24,
    parameter int unsigned SET_LSB = 55,
    parameter int unsigned CLR_LSB = 45,
    parameter int unsigned VEL_MAX = 327680
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err_a,
    input  logic signed [ERR_W-1:0] err_b,
    input  logic                    ref_tick_a,
    input  logic                    ref_tick_b,
    input  logic signed [VEL_W-1:0] vel_a,
    input  logic signed [VEL_W-1:0] vel_b,
    input  logic                    sig_lost_a,
    input  logic                    sig_lost_b,
    input  logic                    sel_a,
    output logic                    fault_n
);
    localparam int N_CH = 2;
    localparam int EM_W = ERR_W - 1;

    generate
        if (SET_LSB <= CLR_LSB) begin : g_bad_thresholds
            $error("SET_LSB must exceed CLR_LSB");
        end
    endgenerate

    logic signed [N_CH-1:0][ERR_W-1:0] err_w;
    logic signed [N_CH-1:0][VEL_W-1:0] vel_w;
    logic        [N_CH-1:0]            tick_w;
    logic        [N_CH-1:0]            lost_w;
    logic        [N_CH-1:0][EM_W-1:0]  mag_w;
    logic        [N_CH-1:0]            latch_w;
    logic        [N_CH-1:0]            bad_w;

    assign err_w  = {err_b, err_a};
    assign vel_w  = {vel_b, vel_a};
    assign tick_w = {ref_tick_b, ref_tick_a};
    assign lost_w = {sig_lost_b, sig_lost_a};

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        trk_chan_mon #(
            .ERR_W(ERR_W), .VEL_W(VEL_W), .SET_LSB(SET_LSB),
            .CLR_LSB(CLR_LSB), .VEL_MAX(VEL_MAX)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .err(err_w[c]), .ref_tick(tick_w[c]),
            .vel(vel_w[c]), .sig_lost(lost_w[c]), .err_mag(mag_w[c]),
            .err_latch(latch_w[c]), .bad(bad_w[c])
        );
    end

    // Drive the shared flag from the selected channel, one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_n <= 1'b0;
        else
            fault_n <= ~(sel_a ? bad_w[0] : bad_w[1]);
    end
endmodule

// File: rtl/trk_fault_mon_chk.sv
// Assertion checker for trk_fault_mon, bound to every instance.
// Assumes channel 0 is A and channel 1 is B.
module trk_fault_mon_chk #(
    parameter int          MW      = 15,
    parameter int unsigned SET_LSB = 55,
    parameter int unsigned CLR_LSB = 45
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fault_n,
    input logic [1:0][MW-1:0]  mag,
    input logic [1:0]          latch,
    input logic [1:0]          tick,
    input logic [1:0]          bad
);
    localparam logic [MW-1:0] SET_V = SET_LSB[MW-1:0];
    localparam logic [MW-1:0] CLR_V = CLR_LSB[MW-1:0];

    // R1: the first cycle after reset still shows a fault.
    a_r1_reset_faulted: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fault_n);

    // R6, R7: with both channels clean, the flag must read clean.
    a_r6_clean_both: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bad[0]) && !$past(bad[1])) |-> fault_n);

    for (genvar c = 0; c < 2; c++) begin : g_c
        // R2: a set needs a magnitude strictly above the set threshold.
        a_r2_set_over: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $rose(latch[c])) |-> ($past(mag[c]) > SET_V));
        // R4: a set happens only on a reference strobe.
        a_r4_set_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $rose(latch[c])) |-> $past(tick[c]));
        // R3: a clear needs a magnitude below the clear threshold.
        a_r3_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $fell(latch[c])) |-> ($past(mag[c]) < CLR_V));
        // R3: a latched fault holds while the magnitude is at or above clear.
        a_r3_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
            (latch[c] && mag[c] >= CLR_V) |=> latch[c]);
    end
endmodule

bind trk_fault_mon trk_fault_mon_chk #(
    .MW(ERR_W - 1), .SET_LSB(SET_LSB), .CLR_LSB(CLR_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .mag(mag_w),
    .latch(latch_w), .tick(tick_w), .bad(bad_w)
);

// File: tb/trk_fault_mon_tb.sv
`timescale 1ns/1ps
// Directed bench for trk_fault_mon. Inputs change at negedge and results
// are sampled at negedge.
module trk_fault_mon_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] err_a = '0, err_b = '0;
    logic               ref_tick_a = 1'b0, ref_tick_b = 1'b0;
    logic signed [23:0] vel_a = '0, vel_b = '0;
    logic               sig_lost_a = 1'b0, sig_lost_b = 1'b0;
    logic               sel_a = 1'b1;
    logic               fault_n;
    int                 checks = 0;
    int                 failures = 0;

    always #2 clk = ~clk;

    trk_fault_mon u_dut (
        .clk(clk), .rst_n(rst_n), .err_a(err_a), .err_b(err_b),
        .ref_tick_a(ref_tick_a), .ref_tick_b(ref_tick_b),
        .vel_a(vel_a), .vel_b(vel_b), .sig_lost_a(sig_lost_a),
        .sig_lost_b(sig_lost_b), .sel_a(sel_a), .fault_n(fault_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp);
        checks++;
        if (fault_n !== exp) begin
            failures++;
            $display("FAIL %s: fault_n=%b expected=%b at %0t", req, fault_n, exp, $time);
        end
    endtask

    task automatic pulse_a();
        ref_tick_a = 1'b1; step(1); ref_tick_a = 1'b0;
    endtask

    task automatic pulse_b();
        ref_tick_b = 1'b1; step(1); ref_tick_b = 1'b0;
    endtask

    // R1: reset state and hold until settled.
    task automatic t_reset();
        err_a = 16'sd100; err_b = 16'sd100;
        step(2); chk("R1 during reset", 1'b0);
        rst_n = 1'b1;
        step(3); chk("R1 held after reset", 1'b0);
        err_a = 16'sd0; err_b = 16'sd0;
        step(1); chk("R1 one edge after settle", 1'b0);
        step(1); chk("R1 released", 1'b1);
    endtask

    // R4: two strobes needed; a dip restarts the count.
    task automatic t_persist();
        err_a = 16'sd56; step(1);
        pulse_a(); step(3); chk("R4 single strobe", 1'b1);
        pulse_a(); chk("R4 edge of set", 1'b1);
        step(1); chk("R4 set after second strobe", 1'b0);
        err_a = 16'sd0; step(2); chk("R4 cleared", 1'b1);
        err_a = 16'sd60; pulse_a();
        err_a = 16'sd55; step(1);
        err_a = 16'sd60; pulse_a(); step(2); chk("R4 dip restarts", 1'b1);
        pulse_a(); step(1); chk("R4 set after restart", 1'b0);
        err_a = 16'sd0; step(2); chk("R4 cleared again", 1'b1);
    endtask

    // R2: equal to the set threshold never qualifies.
    task automatic t_set_edge();
        err_a = 16'sd55;
        pulse_a(); step(1); pulse_a(); pulse_a(); step(2);
        chk("R2 equal to set", 1'b1);
        err_a = 16'sd0; step(1);
    endtask

    // R3: hysteresis band.
    task automatic t_hyst();
        err_a = 16'sd60; pulse_a(); pulse_a(); step(1);
        chk("R3 raised", 1'b0);
        err_a = 16'sd50; step(4); chk("R3 hold at 50", 1'b0);
        err_a = 16'sd45; step(4); chk("R3 hold at 45", 1'b0);
        err_a = 16'sd44; step(1); chk("R3 one edge after 44", 1'b0);
        step(1); chk("R3 clear at 44", 1'b1);
    endtask

    // R5: negative errors and the most negative code.
    task automatic t_neg();
        err_a = -16'sd60; pulse_a(); pulse_a(); step(1);
        chk("R5 negative sets", 1'b0);
        err_a = -16'sd45; step(3); chk("R5 negative holds", 1'b0);
        err_a = -16'sd44; step(2); chk("R5 negative clears", 1'b1);
        err_a = 16'sh8000; pulse_a(); pulse_a(); step(1);
        chk("R5 min code saturates", 1'b0);
        err_a = 16'sd0; step(2); chk("R5 cleared", 1'b1);
    endtask

    // R6, R7: channel isolation and select latency.
    task automatic t_select();
        sel_a = 1'b1;
        err_b = 16'sd70; pulse_b(); pulse_b(); step(2);
        chk("R6 B fault hidden", 1'b1);
        sel_a = 1'b0; step(1); chk("R7 switch to B", 1'b0);
        sel_a = 1'b1; step(1); chk("R7 switch to A", 1'b1);
        err_b = 16'sd0; sel_a = 1'b0; step(2); chk("R7 B cleared", 1'b1);
        sel_a = 1'b1; step(1);
    endtask

    // R8: velocity limit.
    task automatic t_vel();
        vel_a = 24'sd327681; step(1); chk("R8 one edge", 1'b1);
        step(1); chk("R8 over velocity", 1'b0);
        vel_a = 24'sd327680; step(2); chk("R8 at limit", 1'b1);
        vel_a = -24'sd327681; step(2); chk("R8 negative over", 1'b0);
        vel_a = 24'sd0; step(2); chk("R8 released", 1'b1);
        vel_b = 24'sd400000; step(2); chk("R6 B velocity hidden", 1'b1);
        vel_b = 24'sd0; step(2);
    endtask

    // R9: signal-loss flag.
    task automatic t_lost();
        sel_a = 1'b0; step(1);
        sig_lost_b = 1'b1; step(2); chk("R9 loss faults", 1'b0);
        sig_lost_b = 1'b0; step(2); chk("R9 loss released", 1'b1);
        sig_lost_a = 1'b1; step(2); chk("R6 A loss hidden", 1'b1);
        sel_a = 1'b1; step(1); chk("R9 A loss on select", 1'b0);
        sig_lost_a = 1'b0; step(2); chk("R9 A released", 1'b1);
    endtask

    initial begin
        t_reset();
        t_persist();
        t_set_edge();
        t_hyst();
        t_neg();
        t_select();
        t_vel();
        t_lost();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule